// File: doc/BRIEF.md
# Four-State Snooping Write-Back Cache Controller

This block sits between one processor and a shared, atomic snooping bus. It runs a small direct-mapped cache with one data word per line, and each line carries one of four coherence states: invalid, shared, exclusive-clean or modified. Processor reads and writes that hit complete locally. Misses, and writes that need ownership, request the bus, wait for a grant and issue one transaction. A dirty victim is first written back with its own transaction.

At the same time the block watches every transaction that another cache issues on the bus. When it holds the line that a read refers to, it raises its share vote. If it holds that line modified, it drives the line's data onto the bus and keeps a shared copy. A read-for-ownership from another cache makes it drop the line, supplying the data first if the line is dirty. The share votes of all other caches are ORed into `bus_shared_in`. A requester samples that input when its read completes, and so fills either exclusive-clean or shared. A later write to an exclusive-clean line then needs no bus traffic.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, and `bus_req`, `cpu_ready`, `snp_shared` and `snp_flush` are low.
- R2: A read miss requests the bus with command 1 (read). When the grant arrives, the line fills with `bus_rdata`. It fills exclusive-clean if `bus_shared_in` is low in the grant cycle and shared if it is high.
- R3: A read that hits a valid line returns its data without requesting the bus.
- R4: A write to an exclusive-clean or modified line stores the data and leaves the line modified without requesting the bus.
- R5: A write to a shared line, or a write that misses, requests the bus with command 2 (read-for-ownership). After the grant the line is modified and holds the written word.
- R6: When another cache reads (command 1) and the line is valid here, `snp_shared` is high in that cycle. A modified line also raises `snp_flush` and drives its word on `snp_data`. A modified or exclusive-clean line becomes shared.
- R7: When another cache issues command 2 and the line is valid here, the line becomes invalid. A modified line first raises `snp_flush` with its word.
- R8: A miss whose victim is modified first issues command 3 (write-back) with the victim's address and word, and then issues the access's own transaction. A shared or exclusive-clean victim is dropped with no bus transaction.
- R9: While a bus transaction is outstanding, `cpu_ready` stays low, and `bus_req`, `bus_cmd` and `bus_addr` stay constant until the grant. `cpu_ready` is a single-cycle pulse.
- R10: If a snooped transaction changes the line that a waiting local request concerns, the snoop takes effect first. The local request withdraws `bus_req`, looks at the line again and issues a command chosen from the updated state, which can replace a write-back by a plain fill.
- R11: With several controllers on one bus, every read returns the value of the latest write to that address made by any processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; the low bits select the line |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | One-cycle grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back word |
| bus_rdata | input | DW | Fill word in the grant cycle |
| bus_shared_in | input | 1 | Wired-OR share vote of the other caches |
| snp_cmd | input | 2 | Command of another cache's transaction, 0 when none |
| snp_addr | input | AW | Address of the snooped transaction |
| snp_shared | output | 1 | Share vote of this cache |
| snp_flush | output | 1 | This cache supplies the word |
| snp_data | output | DW | Supplied word |

## Verification
The assertions rely on three properties of the bus. It grants one cache at a time, for a single cycle, and only while that cache requests. It never shows a cache its own transaction on the snoop inputs. It leaves at least one idle cycle between transactions, so that a snooped change reaches a waiting requester before the next arbitration. The processor is assumed to hold its request fields steady until the ready pulse. The bench's behavioural bus keeps to all of this. It uses a fixed-priority arbiter that waits one cycle after each grant, and its processor tasks drive each access at a falling edge and release it only after sampling ready.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output line_st_t         lk_st,
  output logic [DW-1:0]    lk_data,
  input  logic             lcl_we,
  input  logic [TAG_W-1:0] lcl_tag,
  input  line_st_t         lcl_st,
  input  logic [DW-1:0]    lcl_data,
  input  logic [IDX_W-1:0] sn_idx,
  output logic [TAG_W-1:0] sn_tag,
  output line_st_t         sn_st,
  output logic [DW-1:0]    sn_data,
  input  logic             sn_we,
  input  line_st_t         sn_st_new
);
  line_st_t         st_q   [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
    end else begin
      if (lcl_we) st_q[lk_idx] <= lcl_st;
      if (sn_we)  st_q[sn_idx] <= sn_st_new;
    end
  end

  always_ff @(posedge clk) begin
    if (lcl_we) begin
      tag_q[lk_idx]  <= lcl_tag;
      data_q[lk_idx] <= lcl_data;
    end
  end

  assign lk_tag  = tag_q[lk_idx];
  assign lk_st   = st_q[lk_idx];
  assign lk_data = data_q[lk_idx];
  assign sn_tag  = tag_q[sn_idx];
  assign sn_st   = st_q[sn_idx];
  assign sn_data = data_q[sn_idx];

  // R10
  port_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (lcl_we && sn_we) |-> (lk_idx != sn_idx));
endmodule

// File: rtl/mesi_snoop_logic.sv
module mesi_snoop_logic
  import mesi_pkg::*;
(
  input  bus_cmd_t cmd,
  input  logic     tag_eq,
  input  line_st_t st,
  output logic     shared,
  output logic     flush,
  output logic     st_we,
  output line_st_t st_new
);
  logic present;
  assign present = tag_eq && (st != LN_I);

  always_comb begin
    shared = 1'b0;
    flush  = 1'b0;
    st_we  = 1'b0;
    st_new = st;
    case (cmd)
      BC_RD: begin
        shared = present;
        flush  = present && (st == LN_M);
        st_we  = present && (st != LN_S);
        st_new = LN_S;
      end
      BC_RDX: begin
        flush  = present && (st == LN_M);
        st_we  = present;
        st_new = LN_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_in,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_LOOK, F_WAIT, F_DONE} fsm_t;

  fsm_t          fsm_q;
  logic          op_we_q, req_q, rdy_q;
  logic [AW-1:0] op_addr_q, baddr_q;
  logic [DW-1:0] op_wdata_q, bdata_q, rdata_q;
  bus_cmd_t      cmd_q;

  logic [IDX_W-1:0] idx, sn_idx;
  logic [TAG_W-1:0] tag, sn_tag_in, lk_tag, sn_tag, lcl_tag;
  line_st_t         lk_st, sn_st, lcl_st, sn_st_new;
  logic [DW-1:0]    lk_data, sn_data, lcl_data;
  logic             lcl_we, sn_we, sh, fl, snp_same, lk_hit;

  assign idx       = op_addr_q[IDX_W-1:0];
  assign tag       = op_addr_q[AW-1:IDX_W];
  assign sn_idx    = snp_addr[IDX_W-1:0];
  assign sn_tag_in = snp_addr[AW-1:IDX_W];

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .lk_idx(idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
    .lcl_we(lcl_we), .lcl_tag(lcl_tag), .lcl_st(lcl_st), .lcl_data(lcl_data),
    .sn_idx(sn_idx), .sn_tag(sn_tag), .sn_st(sn_st), .sn_data(sn_data),
    .sn_we(sn_we), .sn_st_new(sn_st_new)
  );

  mesi_snoop_logic u_snoop (
    .cmd(bus_cmd_t'(snp_cmd)), .tag_eq(sn_tag == sn_tag_in), .st(sn_st),
    .shared(sh), .flush(fl), .st_we(sn_we), .st_new(sn_st_new)
  );

  assign snp_same = sn_we && (sn_idx == idx);
  assign lk_hit   = (lk_st != LN_I) && (lk_tag == tag);

  always_comb begin
    lcl_we   = 1'b0;
    lcl_tag  = tag;
    lcl_st   = lk_st;
    lcl_data = lk_data;
    case (fsm_q)
      F_LOOK:
        if (!snp_same && lk_hit && op_we_q && (lk_st == LN_M || lk_st == LN_E)) begin
          lcl_we   = 1'b1;
          lcl_st   = LN_M;
          lcl_data = op_wdata_q;
        end
      F_WAIT:
        if (bus_gnt) begin
          case (cmd_q)
            BC_WB:  begin lcl_we = 1'b1; lcl_tag = lk_tag; lcl_st = LN_I; end
            BC_RD:  begin lcl_we = 1'b1; lcl_st = bus_shared_in ? LN_S : LN_E; lcl_data = bus_rdata; end
            BC_RDX: begin lcl_we = 1'b1; lcl_st = LN_M; lcl_data = op_wdata_q; end
            default: ;
          endcase
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q      <= F_IDLE;
      req_q      <= 1'b0;
      rdy_q      <= 1'b0;
      cmd_q      <= BC_NONE;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      baddr_q    <= '0;
      bdata_q    <= '0;
      rdata_q    <= '0;
    end else begin
      rdy_q <= 1'b0;
      case (fsm_q)
        F_IDLE:
          if (cpu_req) begin
            op_we_q    <= cpu_we;
            op_addr_q  <= cpu_addr;
            op_wdata_q <= cpu_wdata;
            fsm_q      <= F_LOOK;
          end
        F_LOOK:
          if (!snp_same) begin
            if (lk_hit && !(op_we_q && lk_st == LN_S)) begin
              if (!op_we_q) rdata_q <= lk_data;
              rdy_q <= 1'b1;
              fsm_q <= F_DONE;
            end else begin
              req_q   <= 1'b1;
              fsm_q   <= F_WAIT;
              bdata_q <= lk_data;
              if (!lk_hit && lk_st == LN_M) begin
                cmd_q   <= BC_WB;
                baddr_q <= {lk_tag, idx};
              end else begin
                cmd_q   <= op_we_q ? BC_RDX : BC_RD;
                baddr_q <= op_addr_q;
              end
            end
          end
        F_WAIT:
          if (bus_gnt) begin
            req_q <= 1'b0;
            cmd_q <= BC_NONE;
            if (cmd_q == BC_WB) begin
              fsm_q <= F_LOOK;
            end else begin
              if (cmd_q == BC_RD) rdata_q <= bus_rdata;
              rdy_q <= 1'b1;
              fsm_q <= F_DONE;
            end
          end else if (snp_same) begin
            req_q <= 1'b0;
            cmd_q <= BC_NONE;
            fsm_q <= F_LOOK;
          end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign cpu_rdata  = rdata_q;
  assign cpu_ready  = rdy_q;
  assign bus_req    = req_q;
  assign bus_cmd    = cmd_q;
  assign bus_addr   = baddr_q;
  assign bus_wdata  = bdata_q;
  assign snp_shared = sh;
  assign snp_flush  = fl;
  assign snp_data   = fl ? sn_data : '0;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_same) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R2
  cmd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_cmd != 2'd0));
  // R6
  shared_rd_chk: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> (snp_cmd == 2'd1));
endmodule

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cpu_req [NC];
  logic          cpu_we  [NC];
  logic [AW-1:0] cpu_addr[NC];
  logic [DW-1:0] cpu_wdata[NC];
  logic [DW-1:0] cpu_rdata[NC];
  logic          cpu_ready[NC];
  logic          bus_req [NC];
  logic          bus_gnt [NC];
  logic [1:0]    bus_cmd [NC];
  logic [AW-1:0] bus_addr[NC];
  logic [DW-1:0] bus_wdata[NC];
  logic [DW-1:0] bus_rdata[NC];
  logic          shared_in[NC];
  logic [1:0]    snp_cmd [NC];
  logic          snp_shared[NC];
  logic          snp_flush[NC];
  logic [DW-1:0] snp_data[NC];

  logic [DW-1:0] mem [256];
  logic [1:0]    gnt;
  logic          block;
  int            total = 0, bad = 0;
  logic [1:0]    cmd_log [NC][64];
  int            rec_n [NC];
  int            win;
  logic [1:0]    bcmd;
  logic [AW-1:0] baddr;

  for (genvar i = 0; i < NC; i++) begin : g_c
    mesi_cache_ctrl #(.AW(AW), .DW(DW), .LINES(4)) dut (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req[i]), .cpu_we(cpu_we[i]), .cpu_addr(cpu_addr[i]),
      .cpu_wdata(cpu_wdata[i]), .cpu_rdata(cpu_rdata[i]), .cpu_ready(cpu_ready[i]),
      .bus_req(bus_req[i]), .bus_gnt(bus_gnt[i]), .bus_cmd(bus_cmd[i]),
      .bus_addr(bus_addr[i]), .bus_wdata(bus_wdata[i]), .bus_rdata(bus_rdata[i]),
      .bus_shared_in(shared_in[i]), .snp_cmd(snp_cmd[i]), .snp_addr(baddr),
      .snp_shared(snp_shared[i]), .snp_flush(snp_flush[i]), .snp_data(snp_data[i])
    );
  end

  // behavioural bus: one-cycle grants, an idle cycle after each, higher index wins
  always_comb begin
    win   = gnt[1] ? 1 : 0;
    bcmd  = (gnt != 2'b00) ? bus_cmd[win] : 2'd0;
    baddr = bus_addr[win];
    for (int i = 0; i < NC; i++) begin
      bus_gnt[i]   = gnt[i];
      snp_cmd[i]   = gnt[i] ? 2'd0 : bcmd;
      shared_in[i] = snp_shared[1-i];
      bus_rdata[i] = snp_flush[1-i] ? snp_data[1-i] : mem[bus_addr[i]];
    end
  end

  always @(posedge clk) begin
    if (rst) gnt <= 2'b00;
    else if (gnt != 2'b00) gnt <= 2'b00;
    else if (!block) begin
      if (bus_req[1]) gnt <= 2'b10;
      else if (bus_req[0]) gnt <= 2'b01;
    end
  end

  always @(posedge clk) begin
    if (!rst && gnt != 2'b00) begin
      cmd_log[win][rec_n[win] % 64] = bus_cmd[win];
      rec_n[win] = rec_n[win] + 1;
      if (snp_flush[0]) mem[baddr] <= snp_data[0];
      else if (snp_flush[1]) mem[baddr] <= snp_data[1];
      else if (bus_cmd[win] == 2'd3) mem[baddr] <= bus_wdata[win];
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output logic [1:0] c0, output int n);
    int n0;
    n0 = rec_n[c];
    @(negedge clk);
    cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = d;
    do @(negedge clk); while (!cpu_ready[c]);
    rd = cpu_rdata[c];
    cpu_req[c] = 1'b0;
    n  = rec_n[c] - n0;
    c0 = (n > 0) ? cmd_log[c][n0 % 64] : 2'd0;
  endtask

  // {cache, we, addr, wdata, expected read, first command, command count}
  localparam logic [45:0] VEC [25] = '{
    {1'b0,1'b0,8'h10,16'h0000,16'h1010,2'd1,2'd1},  // R2 miss, fill E
    {1'b0,1'b1,8'h10,16'hAAAA,16'h0000,2'd0,2'd0},  // R4 silent E->M
    {1'b0,1'b0,8'h10,16'h0000,16'hAAAA,2'd0,2'd0},  // R3 hit
    {1'b1,1'b0,8'h10,16'h0000,16'hAAAA,2'd1,2'd1},  // R6 flush from M
    {1'b0,1'b0,8'h10,16'h0000,16'hAAAA,2'd0,2'd0},  // R3 hit in S
    {1'b1,1'b1,8'h10,16'hBBBB,16'h0000,2'd2,2'd1},  // R5 S->M
    {1'b0,1'b0,8'h10,16'h0000,16'hBBBB,2'd1,2'd1},  // R7 was invalidated
    {1'b1,1'b1,8'h10,16'hCCCC,16'h0000,2'd2,2'd1},  // R5
    {1'b1,1'b1,8'h14,16'hDDDD,16'h0000,2'd3,2'd2},  // R8 dirty victim
    {1'b0,1'b0,8'h10,16'h0000,16'hCCCC,2'd1,2'd1},  // R8 memory updated
    {1'b0,1'b1,8'h10,16'hEEEE,16'h0000,2'd0,2'd0},  // R2 filled E
    {1'b1,1'b0,8'h20,16'h0000,16'h1020,2'd3,2'd2},  // R8
    {1'b0,1'b0,8'h24,16'h0000,16'h1024,2'd3,2'd2},  // R8
    {1'b1,1'b0,8'h21,16'h0000,16'h1021,2'd1,2'd1},
    {1'b1,1'b0,8'h25,16'h0000,16'h1025,2'd1,2'd1},  // R8 silent E eviction
    {1'b0,1'b0,8'h21,16'h0000,16'h1021,2'd1,2'd1},
    {1'b0,1'b1,8'h21,16'hFFFF,16'h0000,2'd0,2'd0},  // R4 no share vote seen
    {1'b1,1'b0,8'h21,16'h0000,16'hFFFF,2'd1,2'd1},  // R6
    {1'b0,1'b1,8'h32,16'h1234,16'h0000,2'd2,2'd1},  // R5 write miss
    {1'b1,1'b0,8'h32,16'h0000,16'h1234,2'd1,2'd1},
    {1'b0,1'b0,8'h03,16'h0000,16'h1003,2'd1,2'd1},
    {1'b1,1'b0,8'h03,16'h0000,16'h1003,2'd1,2'd1},  // R6 E->S, fill S
    {1'b1,1'b1,8'h03,16'h5555,16'h0000,2'd2,2'd1},  // R6 proves S
    {1'b0,1'b0,8'h03,16'h0000,16'h5555,2'd1,2'd1},  // R7
    {1'b0,1'b0,8'h10,16'h0000,16'hEEEE,2'd1,2'd1}   // R8 data written back
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, rd1;
    logic [1:0]    fc, fc1;
    int            n, n1;
    string         t;
    block = 1'b0;
    for (int i = 0; i < NC; i++) begin
      cpu_req[i] = 0; cpu_we[i] = 0; cpu_addr[i] = '0; cpu_wdata[i] = '0; rec_n[i] = 0;
    end
    for (int a = 0; a < 256; a++) mem[a] = 16'h1000 + 16'(a);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      // R1
      chk(!bus_req[i] && !cpu_ready[i] && !snp_shared[i] && !snp_flush[i], "R1 idle outputs",
          {bus_req[i], cpu_ready[i], snp_shared[i], snp_flush[i]}, 0);
    end

    for (int k = 0; k < 25; k++) begin
      logic [45:0] v;
      v = VEC[k];
      do_op(int'(v[45]), v[44], v[43:36], v[35:20], rd, fc, n);
      if (v[1:0] == 2'd0) t = v[44] ? "R4 no bus traffic" : "R3 no bus traffic";
      else if (k == 22) t = "R6 fill was shared";
      else if (v[3:2] == 2'd1) t = "R2 read command";
      else if (v[3:2] == 2'd2) t = "R5 ownership command";
      else t = "R8 write-back first";
      chk(n == int'(v[1:0]) && fc == v[3:2], t, {n, 2'b0, fc}, {int'(v[1:0]), 2'b0, v[3:2]});
      if (!v[44]) begin
        t = (k == 3 || k == 17) ? "R6 flushed data" : (k == 6 || k == 23) ? "R7 read data" : "R11 read data";
        chk(rd == v[19:4], t, rd, v[19:4]);
      end
      if (k == 8) chk(mem[8'h10] == 16'hCCCC, "R8 memory after write-back", mem[8'h10], 16'hCCCC);
    end

    // R9 stall while grant withheld
    block = 1'b1;
    fork
      do_op(0, 1'b0, 8'h0D, '0, rd, fc, n);
      begin
        repeat (8) @(negedge clk);
        chk(!cpu_ready[0] && bus_req[0] && bus_cmd[0] == 2'd1 && bus_addr[0] == 8'h0D,
            "R9 stalled request", {cpu_ready[0], bus_req[0], bus_cmd[0], bus_addr[0]}, {1'b0, 1'b1, 2'd1, 8'h0D});
        block = 1'b0;
      end
    join
    chk(rd == 16'h100D, "R9 data after grant", rd, 16'h100D);

    // R10 snoop overtakes a pending write-back of the same line
    do_op(0, 1'b1, 8'h08, 16'h7777, rd, fc, n);
    chk(fc == 2'd2 && n == 1, "R5 write miss ownership", fc, 2);
    block = 1'b1;
    fork
      do_op(0, 1'b0, 8'h0C, '0, rd, fc, n);
      begin
        wait (bus_req[0]);
        do_op(1, 1'b1, 8'h08, 16'h8888, rd1, fc1, n1);
      end
      begin
        wait (bus_req[0] && bus_req[1]);
        @(negedge clk) block = 1'b0;
      end
    join
    chk(fc == 2'd1 && n == 1, "R10 re-evaluated command", {n, 2'b0, fc}, {1, 2'b0, 2'd1});
    chk(rd == 16'h100C, "R10 read data", rd, 16'h100C);
    chk(mem[8'h08] == 16'h7777, "R7 flushed to memory", mem[8'h08], 16'h7777);
    do_op(0, 1'b0, 8'h08, '0, rd, fc, n);
    chk(rd == 16'h8888, "R11 latest write", rd, 16'h8888);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule